// File: doc/BRIEF.md
# Instruction Fetch Micro-Sequencer

This block is the fetch half of a small multi-cycle processor control unit. It owns four registers: the program counter, the memory address register, the memory buffer register and the instruction register. On a start request it steps through a fixed chain of register-transfer micro-operations to bring one instruction word in from memory. If the fetched word selects direct addressing, it then goes on to fetch the operand that the instruction points at.

A static configuration input selects the schedule. In the grouped schedule, the program counter increment shares a time step with the memory read into the buffer register, because neither depends on the other. In the ungrouped schedule, every micro-operation has a step of its own. Transfers that depend on an earlier one are never merged in either schedule: the address must settle in the address register before memory is read, and the buffer register must hold the word before the instruction register takes it.

Instruction words are 16 bits. Bit 15 is the mode flag (0 = immediate, 1 = direct), bits 14:12 are an opcode that this block only carries, and bits 11:0 are either the immediate constant or the operand address. Memory has a 12-bit address and a 16-bit word. The memory presents the word at the current address while the read strobe is high, and the block captures it at the end of that step.

Top module: `fetch_seq`

## Requirements
- R1: After reset, busy_o, done_o and mem_rd_o are low, and pc_o and ir_o are zero.
- R2: In the first step after a start is accepted, mem_rd_o is low. In the second step, mem_addr_o equals the program counter value held before the start.
- R3: With group_en_i high, pc_o advances by one at the end of the step that has mem_rd_o high. With group_en_i low, it advances one step after that read step, in a step with no read.
- R4: ir_o takes the new instruction only at the end of a step in which mem_rd_o is low, and never earlier than the step that follows the instruction read step.
- R5: With group_en_i high, an immediate-mode fetch (bit 15 = 0) keeps busy_o high for exactly 3 cycles and issues one read.
- R6: With group_en_i low, an immediate-mode fetch keeps busy_o high for exactly 4 cycles and issues one read.
- R7: A direct-mode fetch (bit 15 = 1) adds exactly 2 busy cycles to its schedule's count. It issues a second read, at the address held in bits 11:0 of the instruction.
- R8: When a fetch ends, ir_o holds the word read at the old program counter. operand_o holds the zero-extended bits 11:0 of that word in immediate mode, or the memory word at address bits 11:0 in direct mode.
- R9: done_o is high for exactly one cycle, in the cycle right after busy_o falls, and is never high while busy_o is high.
- R10: start_i is ignored while busy_o is high. A fetch advances the program counter by exactly one, and a start held through a fetch does not begin a second fetch.
- R11: The program counter wraps from 4095 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| group_en_i | input | 1 | Schedule select: 1 = grouped, 0 = one micro-operation per step; change only while idle |
| start_i | input | 1 | Request one fetch; accepted when not busy |
| busy_o | output | 1 | High during every micro-operation step of a fetch |
| done_o | output | 1 | One-cycle pulse marking the end of a fetch |
| mem_addr_o | output | 12 | Memory address (address register contents) |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | 16 | Memory read data for mem_addr_o |
| pc_o | output | 12 | Program counter |
| ir_o | output | 16 | Instruction register |
| operand_o | output | 16 | Operand of the fetched instruction, valid with done_o |

## Verification
The bound checker watches, on every cycle, the orderings that must hold in either schedule. It checks that there is no read in the step that loads the address, that the address register follows the program counter, that the program counter increment coincides with the read only when grouping is on, that the instruction register never loads in a read step, and the shape of the done pulse. Only the bench scenarios can show the absolute step counts per mode and schedule, the operand value and the address of the second read in direct mode. The same holds for the rejection of a start held through a fetch and the program counter wrap after a full sweep of the address space.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PC2MAR,
    ST_READ,
    ST_INC,
    ST_IR,
    ST_AMAR,
    ST_OPRD,
    ST_DONE
  } fstate_e;

  typedef struct packed {
    logic ld_mar_pc;
    logic ld_mar_ir;
    logic ld_mbr;
    logic inc_pc;
    logic ld_ir;
  } uop_t;

endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic group_en_i,
  input  logic start_i,
  input  logic mbr_mode_i,
  output uop_t uop_o,
  output logic busy_o,
  output logic done_o,
  output logic mem_rd_o
);

  fstate_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE,
      ST_DONE:   state_d = start_i ? ST_PC2MAR : ST_IDLE;
      ST_PC2MAR: state_d = ST_READ;
      ST_READ:   state_d = group_en_i ? ST_IR : ST_INC;
      ST_INC:    state_d = ST_IR;
      ST_IR:     state_d = mbr_mode_i ? ST_AMAR : ST_DONE;
      ST_AMAR:   state_d = ST_OPRD;
      ST_OPRD:   state_d = ST_DONE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    uop_o           = '0;
    uop_o.ld_mar_pc = (state_q == ST_PC2MAR);
    uop_o.ld_mar_ir = (state_q == ST_AMAR);
    uop_o.ld_mbr    = (state_q == ST_READ) || (state_q == ST_OPRD);
    // grouped schedule folds the increment into the read step
    uop_o.inc_pc    = (state_q == ST_INC) || ((state_q == ST_READ) && group_en_i);
    uop_o.ld_ir     = (state_q == ST_IR);
  end

  assign busy_o   = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done_o   = (state_q == ST_DONE);
  assign mem_rd_o = uop_o.ld_mbr;

endmodule

// File: rtl/fetch_dp.sv
module fetch_dp
  import fetch_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  uop_t              uop_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mbr_o,
  output logic [DATA_W-1:0] ir_o
);

  localparam logic [ADDR_W-1:0] PcStep = ADDR_W'(1);

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mbr_q, ir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
    end else begin
      if (uop_i.ld_mar_pc)      mar_q <= pc_q;
      else if (uop_i.ld_mar_ir) mar_q <= ir_q[ADDR_W-1:0];
      if (uop_i.ld_mbr)         mbr_q <= mem_rdata_i;
      if (uop_i.inc_pc)         pc_q  <= pc_q + PcStep;
      if (uop_i.ld_ir)          ir_q  <= mbr_q;
    end
  end

  assign pc_o  = pc_q;
  assign mar_o = mar_q;
  assign mbr_o = mbr_q;
  assign ir_o  = ir_q;

endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fetch_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              group_en_i,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [DATA_W-1:0] operand_o
);

  localparam int unsigned ModeBit = DATA_W - 1;
  localparam int unsigned PadW    = DATA_W - ADDR_W;

  uop_t              uop;
  logic [DATA_W-1:0] mbr;

  fetch_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .group_en_i (group_en_i),
    .start_i    (start_i),
    .mbr_mode_i (mbr[ModeBit]),
    .uop_o      (uop),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .mem_rd_o   (mem_rd_o)
  );

  fetch_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .uop_i       (uop),
    .mem_rdata_i (mem_rdata_i),
    .pc_o        (pc_o),
    .mar_o       (mem_addr_o),
    .mbr_o       (mbr),
    .ir_o        (ir_o)
  );

  assign operand_o = ir_o[ModeBit] ? mbr : {{PadW{1'b0}}, ir_o[ADDR_W-1:0]};

endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              group_en_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              mem_rd_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic [DATA_W-1:0] ir_o
);

  localparam logic [ADDR_W-1:0] PcStep = ADDR_W'(1);

  p_no_rd_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !mem_rd_o);

  p_mar_from_pc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> (mem_addr_o == $past(pc_o)));

  p_pc_plus_one_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pc_o) |-> (pc_o == $past(pc_o) + PcStep));

  p_pc_with_rd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (group_en_i && !$stable(pc_o)) |-> $past(mem_rd_o));

  p_pc_after_rd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!group_en_i && !$stable(pc_o)) |-> (!$past(mem_rd_o) && $past(mem_rd_o, 2)));

  p_ir_not_in_rd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ir_o) |-> (!$past(mem_rd_o) && $past(busy_o)));

  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

endmodule

bind fetch_seq fetch_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .group_en_i (group_en_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .mem_rd_o   (mem_rd_o),
  .mem_addr_o (mem_addr_o),
  .pc_o       (pc_o),
  .ir_o       (ir_o)
);

// File: tb/fetch_seq_tb_top.sv
`timescale 1ns/1ps
module fetch_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        group_en = 1'b0;
  logic        start = 1'b0;
  logic        busy, done, mem_rd;
  logic [11:0] mem_addr, pc;
  logic [15:0] mem_rdata, ir, operand;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int wrap_seen = 0;

  always #2.5 clk = ~clk;

  // computed memory image: mode bit mixes address bits, field scrambles the address
  function automatic logic [15:0] mem_word(input logic [11:0] a);
    logic [11:0] f;
    f = a * 12'd37 + 12'd5;
    return {a[0] ^ a[5], a[3:1], f};
  endfunction

  assign mem_rdata = mem_word(mem_addr);

  fetch_seq dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .group_en_i  (group_en),
    .start_i     (start),
    .busy_o      (busy),
    .done_o      (done),
    .mem_addr_o  (mem_addr),
    .mem_rd_o    (mem_rd),
    .mem_rdata_i (mem_rdata),
    .pc_o        (pc),
    .ir_o        (ir),
    .operand_o   (operand)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=200000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic do_fetch(input bit hold);
    logic [11:0] pc0;
    logic [15:0] ir0, instr, exp_op;
    int idx, krd, kpc, nrd, exp_steps;
    logic [11:0] rd2_addr;
    pc0   = pc;
    ir0   = ir;
    instr = mem_word(pc0);
    exp_op = instr[15] ? mem_word(instr[11:0]) : {4'b0, instr[11:0]};
    exp_steps = (group_en ? 3 : 4) + (instr[15] ? 2 : 0);
    idx = 0; krd = 0; kpc = 0; nrd = 0; rd2_addr = '0;
    start = 1'b1;
    @(negedge clk);
    start = hold;
    while (busy && idx < 20) begin
      idx++;
      if (idx == 1) chk(!mem_rd, "R2", "read in first step", 32'(mem_rd), 0);
      if (idx == 2) chk(mem_addr == pc0, "R2", "address in second step", 32'(mem_addr), 32'(pc0));
      if (done) chk(1'b0, "R9", "done while busy", 1, 0);
      if (mem_rd) begin
        nrd++;
        if (nrd == 1) krd = idx;
        else rd2_addr = mem_addr;
      end
      if (kpc == 0 && pc != pc0) kpc = idx;
      if (krd != 0 && idx == krd + 1 && ir0 != instr)
        chk(ir == ir0, "R4", "ir loaded in read step", 32'(ir), 32'(ir0));
      @(negedge clk);
    end
    start = 1'b0;
    chk(done, "R9", "done after busy", 32'(done), 1);
    if (!instr[15])
      chk(idx == exp_steps, group_en ? "R5" : "R6", "immediate busy cycles", 32'(idx), 32'(exp_steps));
    else
      chk(idx == exp_steps, "R7", "direct busy cycles", 32'(idx), 32'(exp_steps));
    chk(nrd == (instr[15] ? 2 : 1), "R7", "read strobes", 32'(nrd), instr[15] ? 2 : 1);
    if (instr[15]) chk(rd2_addr == instr[11:0], "R7", "operand address", 32'(rd2_addr), 32'(instr[11:0]));
    chk(kpc == krd + (group_en ? 1 : 2), "R3", "pc update step", 32'(kpc), 32'(krd + (group_en ? 1 : 2)));
    chk(ir == instr, "R8", "ir value", 32'(ir), 32'(instr));
    chk(operand == exp_op, "R8", "operand value", 32'(operand), 32'(exp_op));
    chk(pc == pc0 + 12'd1, "R10", "pc advance", 32'(pc), 32'(pc0 + 12'd1));
    if (pc0 == 12'hfff) begin
      wrap_seen++;
      chk(pc == 12'h000, "R11", "pc wrap", 32'(pc), 0);
    end
    @(negedge clk);
    chk(!done, "R9", "done width", 32'(done), 0);
    chk(!busy, "R10", "held start restarted", 32'(busy), 0);
  endtask

  initial begin
    #1;
    chk(!busy && !done && !mem_rd, "R1", "reset flags", {busy, done, mem_rd}, 0);
    chk(pc == 0 && ir == 0, "R1", "reset registers", {pc, ir}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && pc == 0, "R1", "after reset release", {busy, done, pc}, 0);
    group_en = 1'b0;
    for (int i = 0; i < 300; i++) do_fetch(i[0]);
    group_en = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 3900; i++) do_fetch(i[1]);
    chk(wrap_seen == 1, "R11", "wrap observed", 32'(wrap_seen), 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule